// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the device-side write-command interpreter for a parallel NOR-style flash. It watches the write-enable strobe of the external bus together with its address and data lines. It recognises an unlock-then-program sequence and then captures the target address and data of the next write. It fires a one-cycle start strobe toward the internal program/erase engine. When that engine finishes, the decoder falls back to read mode without any further bus traffic.

It also accepts single-write erase-suspend and erase-resume commands. A resume has effect only out of a suspended erase. Suspend/resume pairs are counted. Once that count passes a parameterised limit, every later resume starts a hold-off window, and suspend requests inside that window are refused. Write-enable is asynchronous to the system clock and passes through a synchroniser before its edges are detected.

States of the sequencer: `ST_READ` (idle / array read), `ST_UNLK1` (first unlock write seen), `ST_UNLK2` (second unlock write seen), `ST_PSETUP` (program command seen, waiting for the program write), `ST_PCAPT` (program write's falling edge seen, address held), `ST_PRUN` (engine running). Transitions: READ→UNLK1 on a matching first unlock write while the engine is idle. UNLK1→UNLK2 on a matching second unlock write. UNLK2→PSETUP on the program command. UNLK1/UNLK2→READ on any other write. PSETUP→PCAPT on a write-enable falling edge. PCAPT→PRUN on the following rising edge. PRUN→READ when engine busy falls.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_mode` is 1, `suspended` is 0 and `prog_start`, `erase_susp` and `erase_resume` are 0.
- R2: With the engine idle, a write of 0xAA to address 0x555, a write of 0x55 to 0x2AA, and a write of 0xA0 to 0x555 (default parameters) leave the decoder out of read mode, waiting for the program write.
- R3: `prog_addr` takes the address present when write-enable falls during the program write; address changes after that falling edge do not alter it.
- R4: `prog_data` takes the data present when write-enable rises during the program write. `prog_start` pulses high for exactly one clock at that rising edge.
- R5: After the start pulse, `read_mode` stays 0 while `eng_busy` is high and returns to 1 by itself once `eng_busy` falls.
- R6: A write whose address or data breaks the unlock or program sequence returns the decoder to read mode, and a later write then starts no program.
- R7: While `eng_busy` is high, unlock and program writes are ignored: `read_mode` stays 1 and no `prog_start` appears.
- R8: A write of 0xB0 while `erase_active` is 1 and not suspended pulses `erase_susp` and sets `suspended`, even when `eng_busy` is high.
- R9: A write of 0x30 with the engine idle pulses `erase_resume` and clears `suspended` only if `suspended` was 1. Otherwise it has no effect.
- R10: After a resume, a new suspend write is accepted again.
- R11: Once more than PAIR_LIMIT resumes have occurred, a suspend write within HOLD_CYC clocks after a resume is ignored. One made after the window has expired is accepted.
- R12: A suspend write is ignored when `erase_active` is 0 or when already suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Bus write-enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| eng_busy | input | 1 | Program/erase engine running |
| erase_active | input | 1 | An erase is in progress (held while suspended) |
| read_mode | output | 1 | Decoder idle in read mode |
| prog_start | output | 1 | One-cycle program start strobe |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched program data |
| erase_susp | output | 1 | One-cycle erase suspend strobe |
| erase_resume | output | 1 | One-cycle erase resume strobe |
| suspended | output | 1 | Erase currently suspended |

## Verification
Two functions meet in the same cycle when a suspend write lands while the engine reports busy. The busy gate must block every command except the suspend, so the bench forces `eng_busy` high and issues both a full program sequence and a suspend write. It expects only the suspend strobe in its queue. The second meeting point is a resume that crosses the pair limit followed at once by a suspend. The resume must arm the hold-off in the same cycle it clears `suspended`, and the bench judges this by the absence of a suspend strobe until the window has run out.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        ST_READ   = 3'd0,
        ST_UNLK1  = 3'd1,
        ST_UNLK2  = 3'd2,
        ST_PSETUP = 3'd3,
        ST_PCAPT  = 3'd4,
        ST_PRUN   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/fcd_we_sync.sv
module fcd_we_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic we_fall,
    output logic we_rise
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[LAST-1:0], we_n};
        end
    end

    // sh[LAST] is one clock older than sh[LAST-1]
    always_comb begin
        we_fall = sh[LAST] & ~sh[LAST-1];
        we_rise = ~sh[LAST] & sh[LAST-1];
    end
endmodule

// File: rtl/fcd_susp_track.sv
module fcd_susp_track #(
    parameter int PAIR_LIMIT = 1024,
    parameter int HOLD_CYC   = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_hit,
    input  logic res_hit,
    input  logic erase_active,
    output logic suspended,
    output logic erase_susp,
    output logic erase_resume,
    output logic hold_zero
);
    localparam int CW = $clog2(PAIR_LIMIT + 2);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(PAIR_LIMIT + 1);
    localparam logic [CW-1:0] CNT_LIM = CW'(PAIR_LIMIT);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC);

    logic [CW-1:0] pair_cnt;
    logic [HW-1:0] hold_cnt;

    assign hold_zero = (hold_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            suspended    <= 1'b0;
            erase_susp   <= 1'b0;
            erase_resume <= 1'b0;
            pair_cnt     <= '0;
            hold_cnt     <= '0;
        end else begin
            erase_susp   <= 1'b0;
            erase_resume <= 1'b0;
            if (!hold_zero) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
            if (susp_hit && erase_active && !suspended && hold_zero) begin
                suspended  <= 1'b1;
                erase_susp <= 1'b1;
            end else if (res_hit && suspended) begin
                suspended    <= 1'b0;
                erase_resume <= 1'b1;
                if (pair_cnt != CNT_SAT) begin
                    pair_cnt <= pair_cnt + 1'b1;
                end
                if (pair_cnt >= CNT_LIM) begin
                    hold_cnt <= HOLD_LD;
                end
            end
        end
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int              ADDR_W   = 18,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] UNLK1_A = 'h555,
    parameter logic [DATA_W-1:0] UNLK1_D = 'hAA,
    parameter logic [ADDR_W-1:0] UNLK2_A = 'h2AA,
    parameter logic [DATA_W-1:0] UNLK2_D = 'h55,
    parameter logic [DATA_W-1:0] PGM_CMD = 'hA0,
    parameter logic [DATA_W-1:0] SUSP_CMD = 'hB0,
    parameter logic [DATA_W-1:0] RES_CMD  = 'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_fall,
    input  logic              we_rise,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_busy,
    output logic              read_mode,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              susp_hit,
    output logic              res_hit
);
    seq_state_t        st_q, st_d;
    logic [ADDR_W-1:0] addr_lat;
    logic              busy_q;
    logic              u1_match, u2_match, pgm_match;

    always_comb begin
        u1_match  = (addr_lat == UNLK1_A) && (wdata == UNLK1_D);
        u2_match  = (addr_lat == UNLK2_A) && (wdata == UNLK2_D);
        pgm_match = (addr_lat == UNLK1_A) && (wdata == PGM_CMD);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_READ;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READ:   if (we_rise && !eng_busy && u1_match) st_d = ST_UNLK1;
            ST_UNLK1:  if (we_rise) st_d = u2_match  ? ST_UNLK2  : ST_READ;
            ST_UNLK2:  if (we_rise) st_d = pgm_match ? ST_PSETUP : ST_READ;
            ST_PSETUP: if (we_fall) st_d = ST_PCAPT;
            ST_PCAPT:  if (we_rise) st_d = ST_PRUN;
            ST_PRUN:   if (busy_q && !eng_busy) st_d = ST_READ;
            default:   st_d = ST_READ;
        endcase
    end

    // registered outputs and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lat   <= '0;
            prog_addr  <= '0;
            prog_data  <= '0;
            prog_start <= 1'b0;
            busy_q     <= 1'b0;
        end else begin
            busy_q     <= eng_busy;
            prog_start <= (st_q == ST_PCAPT) && we_rise;
            if (we_fall) begin
                addr_lat <= addr;
            end
            if ((st_q == ST_PSETUP) && we_fall) begin
                prog_addr <= addr;
            end
            if ((st_q == ST_PCAPT) && we_rise) begin
                prog_data <= wdata;
            end
        end
    end

    always_comb begin
        read_mode = (st_q == ST_READ);
        susp_hit  = read_mode && we_rise && (wdata == SUSP_CMD);
        res_hit   = read_mode && we_rise && !eng_busy && (wdata == RES_CMD);
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PAIR_LIMIT  = 1024,
    parameter int HOLD_CYC    = 256,
    parameter logic [ADDR_W-1:0] UNLK1_A  = 'h555,
    parameter logic [DATA_W-1:0] UNLK1_D  = 'hAA,
    parameter logic [ADDR_W-1:0] UNLK2_A  = 'h2AA,
    parameter logic [DATA_W-1:0] UNLK2_D  = 'h55,
    parameter logic [DATA_W-1:0] PGM_CMD  = 'hA0,
    parameter logic [DATA_W-1:0] SUSP_CMD = 'hB0,
    parameter logic [DATA_W-1:0] RES_CMD  = 'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_busy,
    input  logic              erase_active,
    output logic              read_mode,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_susp,
    output logic              erase_resume,
    output logic              suspended
);
    logic we_fall, we_rise;
    logic susp_hit, res_hit;
    logic hold_zero;

    fcd_we_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_n    (we_n),
        .we_fall (we_fall),
        .we_rise (we_rise)
    );

    fcd_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .UNLK1_A(UNLK1_A), .UNLK1_D(UNLK1_D),
        .UNLK2_A(UNLK2_A), .UNLK2_D(UNLK2_D),
        .PGM_CMD(PGM_CMD), .SUSP_CMD(SUSP_CMD), .RES_CMD(RES_CMD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_fall    (we_fall),
        .we_rise    (we_rise),
        .addr       (addr),
        .wdata      (wdata),
        .eng_busy   (eng_busy),
        .read_mode  (read_mode),
        .prog_start (prog_start),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .susp_hit   (susp_hit),
        .res_hit    (res_hit)
    );

    fcd_susp_track #(.PAIR_LIMIT(PAIR_LIMIT), .HOLD_CYC(HOLD_CYC)) u_susp (
        .clk          (clk),
        .rst_n        (rst_n),
        .susp_hit     (susp_hit),
        .res_hit      (res_hit),
        .erase_active (erase_active),
        .suspended    (suspended),
        .erase_susp   (erase_susp),
        .erase_resume (erase_resume),
        .hold_zero    (hold_zero)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              read_mode,
    input logic              prog_start,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              erase_susp,
    input logic              erase_resume,
    input logic              suspended,
    input logic              hold_zero
);
    // R4: start strobe lasts one clock
    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    // R3: address was taken earlier, on the falling edge, not at the start
    a_r3_addr_held_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $stable(prog_addr));

    // R5: a started program leaves read mode
    a_r5_not_read_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !read_mode);

    // R8: a suspend strobe comes with the suspended flag newly set
    a_r8_susp_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        erase_susp |-> (suspended && !$past(suspended)));

    // R9: resume only out of a suspended erase
    a_r9_resume_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
        erase_resume |-> (!suspended && $past(suspended)));

    // R11: no suspend accepted while the hold-off window runs
    a_r11_no_susp_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        erase_susp |-> $past(hold_zero));

    // R1: strobes never overlap
    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, erase_susp, erase_resume}));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .read_mode    (read_mode),
    .prog_start   (prog_start),
    .prog_addr    (prog_addr),
    .erase_susp   (erase_susp),
    .erase_resume (erase_resume),
    .suspended    (suspended),
    .hold_zero    (hold_zero)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int LIM = 4;
    localparam int HOLD = 40;
    localparam int BUSYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic model_busy = 1'b0;
    logic force_busy = 1'b0;
    logic erase_active = 1'b0;
    logic eng_busy;
    logic read_mode, prog_start, erase_susp, erase_resume, suspended;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int            kind;   // 0 program, 1 suspend, 2 resume
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         req;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;
    assign eng_busy = model_busy | force_busy;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .PAIR_LIMIT(LIM), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .eng_busy(eng_busy), .erase_active(erase_active),
        .read_mode(read_mode), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_susp(erase_susp), .erase_resume(erase_resume),
        .suspended(suspended)
    );

    // engine model: busy from the clock after a start strobe for BUSYC clocks
    initial begin
        forever begin
            @(posedge clk);
            if (prog_start) begin
                model_busy <= 1'b1;
                repeat (BUSYC) @(posedge clk);
                model_busy <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input string req);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor: pops one expected item per observed strobe
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (prog_start || erase_susp || erase_resume)) begin
                int k;
                k = prog_start ? 0 : (erase_susp ? 1 : 2);
                if (sbq.size() == 0) begin
                    chk("unexpected strobe", k, 99);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.req, k, e.kind);
                    if (k == 0) begin
                        chk({e.req, " addr R3"}, prog_addr, e.a);
                        chk({e.req, " data R4"}, prog_data, e.d);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // program write where address changes after the fall and data only before the rise
    task automatic pgm_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = ~d; we_n = 1'b0;
        repeat (5) @(negedge clk);
        addr = ~a; wdata = d;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        addr = '0; wdata = '0;
    endtask

    task automatic unlock_pgm();
        wr('h555, 'hAA);
        wr('h2AA, 'h55);
        wr('h555, 'hA0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 read_mode", read_mode, 1);
        chk("R1 suspended", suspended, 0);
        chk("R1 strobes", {prog_start, erase_susp, erase_resume}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2..R5 program sequence
        unlock_pgm();
        chk("R2 left read mode", read_mode, 0);
        expect_ev(0, 'h12345, 'h3C, "R4 prog start");
        pgm_write('h12345, 'h3C);
        chk("R5 busy not read", read_mode, 0);
        repeat (30) @(negedge clk);
        chk("R5 back to read", read_mode, 1);

        // second program with other values
        unlock_pgm();
        expect_ev(0, 'h00F0F, 'hC3, "R4 prog start 2");
        pgm_write('h00F0F, 'hC3);
        repeat (30) @(negedge clk);
        chk("R5 back to read 2", read_mode, 1);

        // R6 broken sequences
        wr('h555, 'hAA);
        wr('h123, 'h55);
        chk("R6 bad unlock2", read_mode, 1);
        wr('h100, 'h77);
        wr('h555, 'hAA);
        wr('h2AA, 'h55);
        wr('h555, 'h90);
        chk("R6 bad command", read_mode, 1);
        wr('h200, 'h11);
        chk("R6 no program", read_mode, 1);

        // R7 busy blocks decoding
        force_busy = 1'b1;
        unlock_pgm();
        chk("R7 busy blocks", read_mode, 1);
        wr('h300, 'h22);
        chk("R7 busy no program", read_mode, 1);
        force_busy = 1'b0;

        // R9 resume without suspend, R12 suspend without erase
        wr('h0, 'h30);
        chk("R9 resume ignored", suspended, 0);
        wr('h0, 'hB0);
        chk("R12 no erase ignored", suspended, 0);

        // R8 suspend while busy
        erase_active = 1'b1;
        force_busy = 1'b1;
        expect_ev(1, '0, '0, "R8 suspend while busy");
        wr('h0, 'hB0);
        chk("R8 suspended", suspended, 1);
        wr('h0, 'hB0);
        chk("R12 double suspend", suspended, 1);
        force_busy = 1'b0;
        expect_ev(2, '0, '0, "R9 resume");
        wr('h0, 'h30);
        chk("R9 cleared", suspended, 0);

        // R10 pairs 2..5
        for (int i = 2; i <= LIM + 1; i++) begin
            expect_ev(1, '0, '0, "R10 suspend after resume");
            wr('h0, 'hB0);
            chk("R10 suspended", suspended, 1);
            expect_ev(2, '0, '0, "R9 resume loop");
            wr('h0, 'h30);
            chk("R9 cleared loop", suspended, 0);
        end

        // R11 past the limit: immediate suspend refused, later one accepted
        wr('h0, 'hB0);
        chk("R11 hold-off refuses", suspended, 0);
        repeat (HOLD + 10) @(negedge clk);
        expect_ev(1, '0, '0, "R11 suspend after hold");
        wr('h0, 'hB0);
        chk("R11 accepted after hold", suspended, 1);
        expect_ev(2, '0, '0, "R11 resume arms hold");
        wr('h0, 'h30);
        wr('h0, 'hB0);
        chk("R11 hold again", suspended, 0);

        repeat (20) @(negedge clk);
        chk("R4 queue drained", sbq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule